// File: doc/BRIEF.md
# Oversampled Receive Clock Recovery

This block finds and tracks the centre of each bit on a serial receive line that is sampled by a fast local clock. The raw line first passes through an optional inverter and a two-stage synchronizer. Each change between the current and the previous synchronized sample is reported as a one-cycle transition pulse. In the oversampled modes, a phase counter of length N (8, 16 or 32 clocks per bit) produces one sample strobe per bit, half a bit after the expected bit boundary. The recovered data bit is registered alongside that strobe.

A two-bit edge selector decides which received transitions may pull the phase. Rising and falling transitions can both count, or only rising ones, or only falling ones, or none. A transition that may pull the phase and arrives away from the expected boundary moves the counter by one step toward it, and does so at most once per bit. When no transitions arrive, the counter keeps its phase and strobes continue. In 1x mode there is no phase tracking: the synchronized data is passed on every clock, and the edge selector has no effect.

Top module: `rx_dpll`

## Requirements
- R1: While `rst_n` is low, `rx_strobe`, `rx_bit` and `rx_edge` are 0, whatever the level of `rx_in`.
- R2: With `os_mode`=00 (1x), `rx_strobe` is high on every cycle and `rx_bit` equals `rx_in ^ rx_inv` from three clock edges earlier, for every value of `edge_sel`.
- R3: With `os_mode` 01, 10 or 11 and no transitions on the line, `rx_strobe` pulses for one cycle every 8, 16 or 32 clocks respectively.
- R4: With `rx_inv`=1, `rx_bit` carries the complement of the line level.
- R5: A change of `rx_in` that is sampled first at clock edge p raises `rx_edge` for exactly the one cycle that follows edge p+1, regardless of `edge_sel`.
- R6: With `edge_sel`=00 and bits of N clocks containing transitions, the loop locks. Each strobe then appears 2+N/2 clock edges after the first edge that samples the bit's leading transition, and `rx_bit` holds that bit.
- R7: A transition may move the phase only if `edge_sel` accepts it: 00 accepts rising and falling, 01 accepts rising only, 10 accepts falling only, 11 accepts none. A transition that is not accepted leaves the strobe spacing at N.
- R8: The phase moves by at most one clock per bit. With a pulse of one clock on the line, two transitions fall within one bit, but only the first one acts. Every strobe spacing is N-1, N or N+1.
- R9: An accepted transition seen in the second half of the bit (early) shortens the current strobe spacing to N-1. One seen in the first half (late) lengthens it to N+1. Spacing then returns to N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Raw serial receive line |
| os_mode | input | 2 | 00 = 1x, 01 = 8x, 10 = 16x, 11 = 32x |
| edge_sel | input | 2 | Transitions allowed to correct the phase: 00 both, 01 rising, 10 falling, 11 none |
| rx_inv | input | 1 | Invert the line before it is synchronized |
| rx_bit | output | 1 | Recovered data bit, valid with the strobe |
| rx_strobe | output | 1 | One-cycle sample strobe per recovered bit |
| rx_edge | output | 1 | One-cycle pulse for each synchronized line transition |

## Verification
The phase correction and the once-per-bit limiter can both act on the same bit. The bench provokes this with a one-clock pulse on the line, placed just after a strobe. The pulse makes an early transition followed on the next clock by a late one. The strobe spacing must be N-1, because only the first transition acts; it would be N if the second one also moved the phase. Isolated transitions placed at known offsets from a strobe are judged the same way, by strobe spacing: N-1 when early, N+1 when late, and N when the edge selector rejects the transition.

// File: rtl/rx_dpll.sv
module rx_dpll (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_in,
  input  logic [1:0] os_mode,
  input  logic [1:0] edge_sel,
  input  logic       rx_inv,
  output logic       rx_bit,
  output logic       rx_strobe,
  output logic       rx_edge
);
  localparam int CW = 5;

  logic          sync1, sync2, prev;
  logic [CW-1:0] cnt, mask, half, step;
  logic          adj_done, rise, fall, qual, adj, late, onex, at_mid;

  always_comb begin
    case (os_mode)
      2'd1:    mask = CW'(7);
      2'd2:    mask = CW'(15);
      2'd3:    mask = CW'(31);
      default: mask = '0;
    endcase
  end

  assign half    = (mask >> 1) + CW'(1);
  assign onex    = (os_mode == 2'd0);
  assign at_mid  = (cnt == half);
  assign rise    = sync2 & ~prev;
  assign fall    = ~sync2 & prev;
  assign rx_edge = rise | fall;

  always_comb begin
    case (edge_sel)
      2'd0:    qual = rise | fall;
      2'd1:    qual = rise;
      2'd2:    qual = fall;
      default: qual = 1'b0;
    endcase
  end

  assign late = (cnt < half);
  assign adj  = qual && !onex && (cnt != '0) && !adj_done;
  assign step = !adj ? CW'(1) : (late ? CW'(0) : CW'(2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      prev  <= 1'b0;
    end else begin
      sync1 <= rx_in ^ rx_inv;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      adj_done <= 1'b0;
    end else begin
      cnt <= (cnt + step) & mask;
      if (adj)
        adj_done <= 1'b1;
      else if (at_mid)
        adj_done <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_strobe <= 1'b0;
      rx_bit    <= 1'b0;
    end else begin
      rx_strobe <= onex | at_mid;
      if (onex | at_mid)
        rx_bit <= sync2;
    end
  end

  // R2
  onex_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (onex && $past(os_mode) == 2'd0 && $past(rst_n)) |-> rx_strobe);

  // R2
  onex_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (onex && $past(os_mode) == 2'd0 && $past(rst_n, 3))
      |-> rx_bit == $past(rx_in ^ rx_inv, 3));

  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_strobe && !onex && $stable(os_mode)) |=> !rx_strobe);

  // R8
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!onex && $stable(os_mode) && $past(rst_n))
      |-> (((cnt - $past(cnt)) & mask) <= CW'(2)));

  // R5
  edge_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_edge && $past(rst_n, 3))
      |-> $past(rx_in ^ rx_inv, 2) != $past(rx_in ^ rx_inv, 3));
endmodule

// File: tb/rx_dpll_test.sv
`timescale 1ns/1ps
module rx_dpll_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_in = 1'b0;
  logic [1:0] os_mode = 2'd1;
  logic [1:0] edge_sel = 2'd0;
  logic       rx_inv = 1'b0;
  logic       rx_bit, rx_strobe, rx_edge;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  rx_dpll uut (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .os_mode(os_mode),
    .edge_sel(edge_sel), .rx_inv(rx_inv), .rx_bit(rx_bit),
    .rx_strobe(rx_strobe), .rx_edge(rx_edge)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_strobe(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!rx_strobe && n < 200);
  endtask

  task automatic t_reset();
    rx_in = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 strobe in reset", rx_strobe, 0);
    chk("R1 bit in reset", rx_bit, 0);
    chk("R1 edge in reset", rx_edge, 0);
    rx_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_onex(input logic [1:0] sel, input logic inv);
    logic [2:0] hist;
    os_mode = 2'd0; edge_sel = sel; rx_inv = inv;
    hist = '0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (k >= 4) begin
        chk("R2 1x strobe", rx_strobe, 1);
        chk("R2 1x data", rx_bit, hist[2] ^ inv);
      end
      hist = {hist[1:0], 1'(((k * 7) >> 1) & 1)};
      rx_in = hist[0];
    end
  endtask

  task automatic t_free(input logic [1:0] m, input int n_exp);
    int n;
    os_mode = m; edge_sel = 2'd0;
    wait_strobe(n);
    wait_strobe(n);
    for (int k = 0; k < 3; k++) begin
      wait_strobe(n);
      chk("R3 free-run spacing", n, n_exp);
    end
  endtask

  task automatic t_edge();
    os_mode = 2'd1; edge_sel = 2'd3;
    repeat (4) @(negedge clk);
    rx_in = ~rx_in;
    @(negedge clk); chk("R5 edge before", rx_edge, 0);
    @(negedge clk); chk("R5 edge pulse", rx_edge, 1);
    @(negedge clk); chk("R5 edge after", rx_edge, 0);
  endtask

  task automatic t_iso(input logic [1:0] sel, input logic rising, input int exp, input string req);
    int n;
    os_mode = 2'd1; edge_sel = sel;
    rx_in = ~rising;
    repeat (3) wait_strobe(n);
    rx_in = rising;
    wait_strobe(n);
    chk(req, n, exp);
    wait_strobe(n);
    chk({req, " settle"}, n, 8);
  endtask

  task automatic t_late();
    int n;
    os_mode = 2'd1; edge_sel = 2'd0;
    repeat (3) wait_strobe(n);
    repeat (3) @(negedge clk);
    rx_in = ~rx_in;
    wait_strobe(n);
    chk("R9 late spacing", n + 3, 9);
    wait_strobe(n);
    chk("R9 late settle", n, 8);
  endtask

  task automatic t_glitch();
    int n;
    os_mode = 2'd1; edge_sel = 2'd0;
    repeat (3) wait_strobe(n);
    rx_in = ~rx_in;
    @(negedge clk);
    rx_in = ~rx_in;
    wait_strobe(n);
    chk("R8 one step per bit", n + 1, 7);
    wait_strobe(n);
    chk("R8 settle", n, 8);
  endtask

  task automatic t_lock(input logic [1:0] m, input int nb, input logic inv);
    int strobes;
    logic b;
    os_mode = m; edge_sel = 2'd0; rx_inv = inv;
    strobes = 0; b = 1'b0;
    for (int k = 0; k < 48 * nb; k++) begin
      @(negedge clk);
      if (rx_strobe && k / nb >= 36) begin
        strobes++;
        chk("R6 lock offset", k % nb, (3 + nb / 2) % nb);
        chk("R6 R4 data", rx_bit, rx_in ^ inv);
      end
      if (k % nb == 0) begin
        b = 1'((k / nb) & 1) ^ 1'(((k / nb) >> 2) & 1);
        rx_in = b;
      end
    end
    chk("R6 one strobe per bit", strobes, 12);
  endtask

  initial begin
    t_reset();
    t_onex(2'd0, 1'b0);
    t_onex(2'd3, 1'b1);
    rx_inv = 1'b0;
    t_free(2'd1, 8);
    t_free(2'd2, 16);
    t_free(2'd3, 32);
    t_edge();
    t_iso(2'd0, 1'b1, 7, "R7 R9 both/rise");
    t_iso(2'd0, 1'b0, 7, "R7 both/fall");
    t_iso(2'd1, 1'b1, 7, "R7 rise/rise");
    t_iso(2'd1, 1'b0, 8, "R7 rise/fall ignored");
    t_iso(2'd2, 1'b1, 8, "R7 fall/rise ignored");
    t_iso(2'd2, 1'b0, 7, "R7 fall/fall");
    t_iso(2'd3, 1'b1, 8, "R7 none/rise ignored");
    t_iso(2'd3, 1'b0, 8, "R7 none/fall ignored");
    t_late();
    t_glitch();
    t_lock(2'd1, 8, 1'b0);
    t_lock(2'd2, 16, 1'b1);
    t_lock(2'd3, 32, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule